// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counter

This block is a register-mapped timer. A divider derived from the input clock paces a 16-bit up-counter. The counter climbs from zero to a programmable ceiling and then wraps. Each wrap is an update event. An update event sets a sticky flag, can raise a level interrupt, and can emit a single-cycle DMA request. Software can also force an update at any time. A forced update restarts the count and loads a new divider value.

Software reaches every setting through a small synchronous bus: address, write strobe, write word and a registered read word. A clock-enable input freezes the whole block while it is low. The divider value is double-buffered, so a new setting takes effect only at an update event. The period in progress therefore always completes with the old value.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0, except the ceiling register at offset 0x2C, which reads 0xFFFF. `irq_o` and `dma_req_o` are low.
- R2: The count advances only while bit 0 of the control word at offset 0x00 is 1. It advances by one on each divider tick. While the bit is 0 the count holds.
- R3: The count runs from 0 up to the ceiling value. On the tick after it reaches the ceiling it returns to 0, and this overflow sets bit 0 of the status word at offset 0x10.
- R4: One divider tick occurs every (divider value + 1) clocks. The divider value is written at offset 0x28.
- R5: A divider write lands in a shadow copy. The working divider takes the shadow value only at an update event, so the period in progress completes with the old value.
- R6: Writing 1 to bit 0 at offset 0x14 forces an update. The count and the divider phase return to 0, and the shadow divider is loaded. This offset always reads 0.
- R7: While control bit 2 is 1, a forced update neither sets the status flag nor requests DMA. An overflow still sets the flag.
- R8: Writing 0 to status bit 0 clears the flag. Writing 1 has no effect. A flag set by an update in the same cycle as a clearing write takes priority.
- R9: Offset 0x24 reads the count in bits 15:0 and a copy of the status flag in bit 31. Writing it loads bits 15:0 into the count, and bit 31 of that write is ignored.
- R10: `irq_o` is high exactly when the status flag is 1 and bit 0 of the enable word at offset 0x0C is 1.
- R11: When bit 8 of the enable word is 1, `dma_req_o` pulses high for one cycle after each update event that is allowed to signal.
- R12: While `clk_en` is low, no register, count or flag changes, and bus writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Block-wide clock enable |
| bus_addr | input | 6 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Registered read word, valid the cycle after the address |
| irq_o | output | 1 | Update interrupt level |
| dma_req_o | output | 1 | Single-cycle DMA request |

## Verification
Every cycle, the checker confirms four rules: a stopped counter holds; a running counter moves by at most one; a tick at the ceiling wraps to zero and raises the flag; a forced update zeroes the count. It also confirms that a suppressed forced update leaves a clear flag clear, and that a low `clk_en` freezes the count, flag and ceiling. Some behaviours appear only over whole sequences, so only the bench scenarios can show them: the exact divider period, the deferral of a divider write to the next update, the read layout of the counter word, the write-1-ignored rule on the status flag, and the number of DMA pulses in a window.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // Register byte offsets (software-visible map)
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_IEN  = 'h0C;
  localparam int unsigned OFF_STAT = 'h10;
  localparam int unsigned OFF_EVG  = 'h14;
  localparam int unsigned OFF_CNT  = 'h24;
  localparam int unsigned OFF_PSC  = 'h28;
  localparam int unsigned OFF_ARR  = 'h2C;

  // Bit positions inside those words
  localparam int CTRL_RUN_BIT     = 0;
  localparam int CTRL_OVFONLY_BIT = 2;
  localparam int IEN_IRQ_BIT      = 0;
  localparam int IEN_DMA_BIT      = 8;

  typedef struct packed {
    logic run;
    logic ovf_only;
  } ctrl_t;

  typedef struct packed {
    logic irq_en;
    logic dma_en;
  } ien_t;
endpackage

// File: rtl/tick_timer_prescale.sv
module tick_timer_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [PSC_W-1:0] psc_pre_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_act_q;
  logic [PSC_W-1:0] phase_q;

  assign tick_o = run_i && (phase_q == psc_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_act_q <= '0;
      phase_q   <= '0;
    end else if (clk_en) begin
      if (reload_i) begin
        psc_act_q <= psc_pre_i;
        phase_q   <= '0;
      end else if (run_i) begin
        phase_q <= tick_o ? '0 : phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic             force_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = (cnt_q == arr_i);
  assign ovf_o  = clk_en && tick_i && at_top && !force_i && !wr_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clk_en) begin
      if (force_i)      cnt_q <= '0;
      else if (wr_i)    cnt_q <= wdata_i;
      else if (tick_i)  cnt_q <= at_top ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_i,
  output ctrl_t             ctrl_o,
  output logic [PSC_W-1:0]  psc_pre_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic              force_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  localparam logic [CNT_W-1:0] ARR_RST = '1;

  ctrl_t             ctrl_q;
  ien_t              ien_q;
  logic [PSC_W-1:0]  psc_pre_q;
  logic [CNT_W-1:0]  arr_q;
  logic              flag_q;
  logic              dma_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              signal_evt;
  logic              unused_wdata;

  logic wr_ctrl, wr_ien, wr_stat, wr_cnt, wr_psc, wr_arr;

  assign wr_ctrl = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_ien  = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_stat = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_cnt  = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign wr_psc  = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_PSC));
  assign wr_arr  = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_ARR));
  assign force_o = clk_en && bus_we && (bus_addr == ADDR_W'(OFF_EVG)) && bus_wdata[0];

  assign cnt_wr_o     = wr_cnt;
  assign cnt_wdata_o  = bus_wdata[CNT_W-1:0];
  assign unused_wdata = ^bus_wdata;

  // Update events that may touch the flag and the DMA line
  assign signal_evt = ovf_i || (force_o && !ctrl_q.ovf_only);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      psc_pre_q <= '0;
      arr_q     <= ARR_RST;
      flag_q    <= 1'b0;
    end else if (clk_en) begin
      if (wr_ctrl) begin
        ctrl_q.run      <= bus_wdata[CTRL_RUN_BIT];
        ctrl_q.ovf_only <= bus_wdata[CTRL_OVFONLY_BIT];
      end
      if (wr_ien) begin
        ien_q.irq_en <= bus_wdata[IEN_IRQ_BIT];
        ien_q.dma_en <= bus_wdata[IEN_DMA_BIT];
      end
      if (wr_psc) psc_pre_q <= bus_wdata[PSC_W-1:0];
      if (wr_arr) arr_q     <= bus_wdata[CNT_W-1:0];
      if (signal_evt)   flag_q <= 1'b1;
      else if (wr_stat) flag_q <= flag_q & bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !clk_en) dma_q <= 1'b0;
    else                dma_q <= signal_evt && ien_q.dma_en;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL): begin
        rd_mux[CTRL_RUN_BIT]     = ctrl_q.run;
        rd_mux[CTRL_OVFONLY_BIT] = ctrl_q.ovf_only;
      end
      ADDR_W'(OFF_IEN): begin
        rd_mux[IEN_IRQ_BIT] = ien_q.irq_en;
        rd_mux[IEN_DMA_BIT] = ien_q.dma_en;
      end
      ADDR_W'(OFF_STAT): rd_mux[0] = flag_q;
      ADDR_W'(OFF_CNT): begin
        rd_mux[CNT_W-1:0]  = cnt_i;
        rd_mux[DATA_W-1]   = flag_q;
      end
      ADDR_W'(OFF_PSC): rd_mux[PSC_W-1:0] = psc_pre_q;
      ADDR_W'(OFF_ARR): rd_mux[CNT_W-1:0] = arr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (clk_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign ctrl_o    = ctrl_q;
  assign psc_pre_o = psc_pre_q;
  assign arr_o     = arr_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & ien_q.irq_en;
  assign dma_req_o = dma_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              dma_req_o
);
  ctrl_t            ctrl_w;
  logic [PSC_W-1:0] psc_pre_w;
  logic [CNT_W-1:0] arr_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_wdata_w;
  logic             force_w, cnt_wr_w, ovf_w, tick_w, flag_w;
  logic             run_w, ovf_only_w;

  assign run_w      = ctrl_w.run;
  assign ovf_only_w = ctrl_w.ovf_only;

  tick_timer_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) u_regs (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_i(cnt_w), .ovf_i(ovf_w),
    .ctrl_o(ctrl_w), .psc_pre_o(psc_pre_w), .arr_o(arr_w),
    .force_o(force_w), .cnt_wr_o(cnt_wr_w), .cnt_wdata_o(cnt_wdata_w),
    .flag_o(flag_w), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  tick_timer_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .run_i(run_w), .reload_i(ovf_w || force_w),
    .psc_pre_i(psc_pre_w), .tick_o(tick_w)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .tick_i(tick_w), .arr_i(arr_w),
    .force_i(force_w), .wr_i(cnt_wr_w), .wdata_i(cnt_wdata_w),
    .cnt_o(cnt_w), .ovf_o(ovf_w)
  );
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              wbit0,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  arr,
  input logic              run,
  input logic              ovf_only,
  input logic              tick,
  input logic              flag
);
  logic frc, cwr, swr;
  assign frc = bus_we && (bus_addr == ADDR_W'(OFF_EVG)) && wbit0;
  assign cwr = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign swr = bus_we && (bus_addr == ADDR_W'(OFF_STAT));

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !run && !frc && !cwr) |=> $stable(cnt));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && run && !frc && !cwr && cnt != arr) |=>
      (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && tick && cnt == arr && !frc && !cwr) |=> (cnt == '0 && flag));

  assert_force_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (clk_en && frc) |=> (cnt == '0));

  assert_force_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (clk_en && frc && ovf_only && !flag) |=> !flag);

  assert_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (!clk_en) |=> ($stable(cnt) && $stable(flag) && $stable(arr)));

  // swr is kept for completeness of decode; flag-clear ordering is bench-checked (R8)
  logic unused_swr;
  assign unused_swr = swr;
endmodule

bind tick_timer tick_timer_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en),
  .bus_addr(bus_addr), .bus_we(bus_we), .wbit0(bus_wdata[0]),
  .cnt(cnt_w), .arr(arr_w), .run(run_w), .ovf_only(ovf_only_w),
  .tick(tick_w), .flag(flag_w)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam logic [5:0] A_CTRL = 6'h00, A_IEN = 6'h0C, A_STAT = 6'h10,
                         A_EVG = 6'h14, A_CNT = 6'h24, A_PSC = 6'h28, A_ARR = 6'h2C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, dma_req_o;

  int checks = 0;
  int errors = 0;
  int dma_pulses = 0;

  always #2.5 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  always @(negedge clk) if (!rst && dma_req_o) dma_pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_reset();
    rst = 1'b1; clk_en = 1'b1; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    dma_pulses = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_for(input int n, input logic [31:0] ctrlv);
    wr(A_CTRL, ctrlv);
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 dma", {31'b0, dma_req_o}, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_IEN, v);  check("R1 ien", v, 0);
    rd(A_STAT, v); check("R1 stat", v, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
    rd(A_PSC, v);  check("R1 psc", v, 0);
    rd(A_ARR, v);  check("R1 arr", v, 32'h0000_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    do_reset();
    run_for(5, 32'h1);
    rd(A_CNT, v); check("R2 count after 5 ticks", v, 5);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); check("R2 hold while stopped", v, 5);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    do_reset();
    wr(A_ARR, 32'd4);
    run_for(4, 32'h1);
    rd(A_CNT, v);  check("R3 at ceiling", v, 4);
    rd(A_STAT, v); check("R3 no flag before wrap", v, 0);
    run_for(1, 32'h1);
    rd(A_CNT, v);  check("R3 wrapped with flag mirror", v, 32'h8000_0000);
    rd(A_STAT, v); check("R3 flag set", v, 1);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    do_reset();
    wr(A_PSC, 32'd2);
    rd(A_PSC, v); check("R4 psc readback", v, 2);
    wr(A_EVG, 32'h1);
    run_for(9, 32'h1);
    rd(A_CNT, v); check("R4 divide by 3", v, 32'h8000_0003);
  endtask

  task automatic t_preload();
    logic [31:0] v;
    do_reset();
    wr(A_ARR, 32'd3);
    wr(A_PSC, 32'd1);
    run_for(8, 32'h1);
    rd(A_CNT, v); check("R5 divider deferred to update", v, 32'h8000_0002);
  endtask

  task automatic t_force();
    logic [31:0] v;
    do_reset();
    wr(A_ARR, 32'd100);
    run_for(7, 32'h1);
    rd(A_CNT, v); check("R6 before force", v, 7);
    wr(A_EVG, 32'h1);
    rd(A_CNT, v); check("R6 forced to zero", v, 32'h8000_0000);
    rd(A_EVG, v); check("R6 evg reads 0", v, 0);
  endtask

  task automatic t_urs();
    logic [31:0] v;
    do_reset();
    wr(A_IEN, 32'h100);
    wr(A_CTRL, 32'h4);
    wr(A_EVG, 32'h1);
    rd(A_STAT, v); check("R7 forced update suppressed", v, 0);
    check("R7 no dma from forced", dma_pulses, 0);
    wr(A_ARR, 32'd2);
    run_for(3, 32'h5);
    rd(A_STAT, v); check("R7 overflow still flags", v, 1);
  endtask

  task automatic t_status();
    logic [31:0] v;
    do_reset();
    wr(A_EVG, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R8 write 1 keeps flag", v, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R8 write 0 clears", v, 0);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R8 write 1 does not set", v, 0);
  endtask

  task automatic t_cntwr();
    logic [31:0] v;
    do_reset();
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, v); check("R9 count write", v, 32'h0000_1234);
    wr(A_CNT, 32'h8000_0005);
    rd(A_CNT, v); check("R9 bit31 write ignored", v, 32'h0000_0005);
    rd(A_STAT, v); check("R9 flag untouched", v, 0);
  endtask

  task automatic t_irq();
    do_reset();
    wr(A_EVG, 32'h1);
    check("R10 irq masked", {31'b0, irq_o}, 0);
    wr(A_IEN, 32'h1);
    check("R10 irq asserted", {31'b0, irq_o}, 1);
    wr(A_STAT, 32'h0);
    check("R10 irq after clear", {31'b0, irq_o}, 0);
  endtask

  task automatic t_dma();
    do_reset();
    wr(A_ARR, 32'd1);
    run_for(6, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 no dma when disabled", dma_pulses, 0);
    do_reset();
    wr(A_IEN, 32'h100);
    wr(A_ARR, 32'd1);
    run_for(6, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 three pulses", dma_pulses, 3);
  endtask

  task automatic t_clken();
    logic [31:0] v;
    do_reset();
    wr(A_CTRL, 32'h1);
    clk_en = 1'b0;
    bus_addr = A_ARR; bus_wdata = 32'd7; bus_we = 1'b1;
    repeat (5) @(negedge clk);
    bus_we = 1'b0;
    clk_en = 1'b1;
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v); check("R12 count frozen", v, 1);
    rd(A_ARR, v); check("R12 write dropped", v, 32'h0000_FFFF);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_wrap();
    t_prescale();
    t_preload();
    t_force();
    t_urs();
    t_status();
    t_cntwr();
    t_irq();
    t_dma();
    t_clken();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule